// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This peripheral watches a free-running system count and escalates in two steps when software stops servicing it. A single programmed offset sets the period. Once the watchdog is enabled and the count reaches the compare value, a first-stage flag rises and drives an interrupt line. At the same moment the compare value moves one offset further ahead. If the count reaches that new compare value before software services the watchdog, a second-stage flag rises on its own output. What the system does with that output is up to the surrounding logic.

Software reaches the block through two independent 4 KB register windows, each with its own simple 32-bit read/write strobe port. The service window has one action: any write to its word at 0x000 restarts the timeout. The configuration window holds a control/status word, the offset, a read-only view of the 64-bit compare value, and an identification word. The identification word is also present in the service window. Keeping the two windows apart lets a system give a low-privilege agent service rights without giving it control over configuration.

Top module: `wdog_twostage`

## Requirements
- R1: A write to service-window address 0x000 loads the compare value with the current system count plus the offset and clears both stage flags, whatever data is written. A write to any other service-window address has no effect.
- R2: Configuration word 0x000 reads as {29'b0, stage-two flag (bit 2), stage-one flag (bit 1), enable (bit 0)}. Only bit 0 is writable. Bits 1 and 2 ignore writes.
- R3: Configuration word 0x008 holds the 32-bit offset and reads back what was written. Writing it loads the compare value with the current count plus the new offset and clears both stage flags.
- R4: The compare value reads back at configuration address 0x010 (bits 31:0) and 0x014 (bits 63:32). Writes to those two addresses are ignored.
- R5: While enabled, on a clock edge where the count is at or above the compare value and the stage-one flag is clear, the stage-one flag and `stage0_irq` assert. At the same edge the compare value reloads with that count plus the offset.
- R6: While enabled with the stage-one flag already set, a clock edge where the count is at or above the compare value sets the stage-two flag and `stage1_out`. `stage1_out` is never high without `stage0_irq`.
- R7: Writing configuration word 0x000 with bit 0 clear disables the watchdog and clears both flags. While disabled, neither stage output asserts, however far the count advances.
- R8: A set stage flag stays set until a service write, an offset write or a disable. Other register traffic and further count progress leave it set.
- R9: Address 0xFCC in each window reads the identification value (parameter `ID_VALUE`, default 32'h0A1D_0057). Every other unlisted address reads 0.
- R10: Read data appears on the window's data port in the cycle after the read strobe and holds until the next read strobe on that window.
- R11: When a service write and an expiry fall on the same edge, the service write wins: no flag is set, and the compare value becomes that count plus the offset.
- R12: After reset the watchdog is disabled, both flags are clear, and the offset and compare value are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_wr | input | 1 | Service window write strobe |
| rf_rd | input | 1 | Service window read strobe |
| rf_addr | input | 12 | Service window byte address |
| rf_wdata | input | 32 | Service window write data (ignored) |
| rf_rdata | output | 32 | Service window read data |
| cf_wr | input | 1 | Configuration window write strobe |
| cf_rd | input | 1 | Configuration window read strobe |
| cf_addr | input | 12 | Configuration window byte address |
| cf_wdata | input | 32 | Configuration window write data |
| cf_rdata | output | 32 | Configuration window read data |
| sys_count | input | CNT_W | Free-running system count |
| stage0_irq | output | 1 | First-stage expiry (interrupt) |
| stage1_out | output | 1 | Second-stage expiry |

## Verification
The bench sweeps several offsets, including zero, and steps the count one value per cycle through both expiries. If the design missed the reload at the first expiry, stage two would fire at once or never. A zero offset checks that stage two still needs a second, separate edge. Counts near a 32-bit carry expose a compare readback that drops or splits its high word. Directed cases cover the following: a service write landing on the exact expiry edge, where a design with the wrong priority would leave the flag set; writes of ones to the status bits and to the compare words, which a careless decode would accept; and a disable followed by a long count advance, which must keep both outputs quiet.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int WORD_W  = 32;
   localparam int FRAME_AW = 12;

   // configuration window
   localparam logic [FRAME_AW-1:0] A_CTRL   = 12'h000;
   localparam logic [FRAME_AW-1:0] A_OFS    = 12'h008;
   localparam logic [FRAME_AW-1:0] A_CMP_LO = 12'h010;
   localparam logic [FRAME_AW-1:0] A_CMP_HI = 12'h014;
   // both windows
   localparam logic [FRAME_AW-1:0] A_IDENT  = 12'hFCC;
   // service window
   localparam logic [FRAME_AW-1:0] A_KICK   = 12'h000;

   localparam int B_EN  = 0;
   localparam int B_ST0 = 1;
   localparam int B_ST1 = 2;

   typedef struct packed {
      logic                wr;
      logic                rd;
      logic [FRAME_AW-1:0] addr;
      logic [WORD_W-1:0]   wdata;
   } win_req_t;
endpackage

// File: rtl/wdog_rd_port.sv
module wdog_rd_port #(
   parameter int W      = 32,
   parameter bit RD_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (RD_REG) begin : g_reg
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= '0;
            else if (rd) q <= din;
         end
         assign dout = q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign dout = rd ? din : '0;
      end
   endgenerate
endmodule

// File: rtl/wdog_stage_engine.sv
module wdog_stage_engine #(
   parameter int CNT_W = 64,
   parameter int OFS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             restart,
   input  logic             disarm,
   input  logic [CNT_W-1:0] count,
   input  logic [OFS_W-1:0] ofs,
   output logic [CNT_W-1:0] cmp,
   output logic             st0,
   output logic             st1
);
   logic [CNT_W-1:0] next_cmp;
   logic             hit;

   assign next_cmp = count + CNT_W'(ofs);
   assign hit      = (count >= cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp <= '0;
         st0 <= 1'b0;
         st1 <= 1'b0;
      end else if (restart) begin
         cmp <= next_cmp;
         st0 <= 1'b0;
         st1 <= 1'b0;
      end else if (disarm) begin
         st0 <= 1'b0;
         st1 <= 1'b0;
      end else if (enable && hit) begin
         if (!st0) begin
            st0 <= 1'b1;
            cmp <= next_cmp;
         end else begin
            st1 <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/wdog_ctrl_frame.sv
module wdog_ctrl_frame
   import wdog_pkg::*;
#(
   parameter int          CNT_W    = 64,
   parameter int          OFS_W    = 32,
   parameter logic [31:0] ID_VALUE = 32'h0A1D_0057,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  win_req_t          req,
   input  logic [CNT_W-1:0]  cmp,
   input  logic              st0,
   input  logic              st1,
   output logic              enable,
   output logic [OFS_W-1:0]  ofs_q,
   output logic [OFS_W-1:0]  ofs_eff,
   output logic              ofs_wr,
   output logic              disarm,
   output logic [WORD_W-1:0] rdata
);
   localparam int CMP_EXT_W = 2 * WORD_W;

   logic                 ctrl_wr;
   logic [CMP_EXT_W-1:0] cmp_ext;
   logic [WORD_W-1:0]    ofs_ext;
   logic [WORD_W-1:0]    ctrl_word;
   logic [WORD_W-1:0]    mux;

   generate
      if (CNT_W == CMP_EXT_W) begin : g_cmp_full
         assign cmp_ext = cmp;
      end else begin : g_cmp_pad
         assign cmp_ext = {{(CMP_EXT_W - CNT_W){1'b0}}, cmp};
      end
      if (OFS_W == WORD_W) begin : g_ofs_full
         assign ofs_ext = ofs_q;
      end else begin : g_ofs_pad
         assign ofs_ext = {{(WORD_W - OFS_W){1'b0}}, ofs_q};
      end
   endgenerate

   assign ctrl_wr = req.wr && (req.addr == A_CTRL);
   assign ofs_wr  = req.wr && (req.addr == A_OFS);
   assign disarm  = ctrl_wr && !req.wdata[B_EN];
   assign ofs_eff = ofs_wr ? req.wdata[OFS_W-1:0] : ofs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         ofs_q  <= '0;
      end else begin
         if (ctrl_wr) enable <= req.wdata[B_EN];
         if (ofs_wr)  ofs_q  <= req.wdata[OFS_W-1:0];
      end
   end

   always_comb begin
      ctrl_word        = '0;
      ctrl_word[B_EN]  = enable;
      ctrl_word[B_ST0] = st0;
      ctrl_word[B_ST1] = st1;
   end

   always_comb begin
      unique case (req.addr)
         A_CTRL:   mux = ctrl_word;
         A_OFS:    mux = ofs_ext;
         A_CMP_LO: mux = cmp_ext[WORD_W-1:0];
         A_CMP_HI: mux = cmp_ext[CMP_EXT_W-1:WORD_W];
         A_IDENT:  mux = ID_VALUE;
         default:  mux = '0;
      endcase
   end

   wdog_rd_port #(.W(WORD_W), .RD_REG(RD_REG)) u_rd (
      .clk  (clk),
      .rst_n(rst_n),
      .rd   (req.rd),
      .din  (mux),
      .dout (rdata)
   );
endmodule

// File: rtl/wdog_refresh_frame.sv
module wdog_refresh_frame
   import wdog_pkg::*;
#(
   parameter logic [31:0] ID_VALUE = 32'h0A1D_0057,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  win_req_t          req,
   output logic              kick,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mux;
   logic              unused_wdata;

   assign unused_wdata = ^req.wdata;
   assign kick         = req.wr && (req.addr == A_KICK);
   assign mux          = (req.addr == A_IDENT) ? ID_VALUE : '0;

   wdog_rd_port #(.W(WORD_W), .RD_REG(RD_REG)) u_rd (
      .clk  (clk),
      .rst_n(rst_n),
      .rd   (req.rd),
      .din  (mux),
      .dout (rdata)
   );
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
   import wdog_pkg::*;
#(
   parameter int          CNT_W    = 64,
   parameter int          OFS_W    = 32,
   parameter logic [31:0] ID_VALUE = 32'h0A1D_0057,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rf_wr,
   input  logic             rf_rd,
   input  logic [11:0]      rf_addr,
   input  logic [31:0]      rf_wdata,
   output logic [31:0]      rf_rdata,
   input  logic             cf_wr,
   input  logic             cf_rd,
   input  logic [11:0]      cf_addr,
   input  logic [31:0]      cf_wdata,
   output logic [31:0]      cf_rdata,
   input  logic [CNT_W-1:0] sys_count,
   output logic             stage0_irq,
   output logic             stage1_out
);
   generate
      if (CNT_W > 2 * WORD_W || CNT_W < OFS_W) begin : g_bad_cnt
         $error("wdog_twostage: CNT_W must lie between OFS_W and 64");
      end
      if (OFS_W < 1 || OFS_W > WORD_W) begin : g_bad_ofs
         $error("wdog_twostage: OFS_W must lie between 1 and 32");
      end
   endgenerate

   win_req_t         rf_req, cf_req;
   logic             kick, ofs_wr, disarm, enable;
   logic [OFS_W-1:0] ofs_val, ofs_eff;
   logic [CNT_W-1:0] cmp_val;
   logic             st0, st1;

   assign rf_req = '{wr: rf_wr, rd: rf_rd, addr: rf_addr, wdata: rf_wdata};
   assign cf_req = '{wr: cf_wr, rd: cf_rd, addr: cf_addr, wdata: cf_wdata};

   wdog_refresh_frame #(.ID_VALUE(ID_VALUE), .RD_REG(RD_REG)) u_rfr (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (rf_req),
      .kick (kick),
      .rdata(rf_rdata)
   );

   wdog_ctrl_frame #(
      .CNT_W(CNT_W), .OFS_W(OFS_W), .ID_VALUE(ID_VALUE), .RD_REG(RD_REG)
   ) u_cfr (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (cf_req),
      .cmp    (cmp_val),
      .st0    (st0),
      .st1    (st1),
      .enable (enable),
      .ofs_q  (ofs_val),
      .ofs_eff(ofs_eff),
      .ofs_wr (ofs_wr),
      .disarm (disarm),
      .rdata  (cf_rdata)
   );

   wdog_stage_engine #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_eng (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .restart(kick | ofs_wr),
      .disarm (disarm),
      .count  (sys_count),
      .ofs    (ofs_eff),
      .cmp    (cmp_val),
      .st0    (st0),
      .st1    (st1)
   );

   assign stage0_irq = st0;
   assign stage1_out = st1;
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
   parameter int CNT_W = 64,
   parameter int OFS_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rf_wr,
   input logic [11:0]      rf_addr,
   input logic             cf_wr,
   input logic [11:0]      cf_addr,
   input logic [31:0]      cf_wdata,
   input logic [CNT_W-1:0] sys_count,
   input logic             stage0_irq,
   input logic             stage1_out,
   input logic [CNT_W-1:0] cmp_val,
   input logic [OFS_W-1:0] ofs_val
);
   p_kick_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr && rf_addr == 12'h000) |=>
         (!stage0_irq && !stage1_out && cmp_val == $past(sys_count) + CNT_W'(ofs_val)));

   p_first_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stage0_irq) |-> ($past(sys_count) >= $past(cmp_val)));

   p_first_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stage0_irq) |-> (cmp_val == $past(sys_count) + CNT_W'(ofs_val)));

   p_stage_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stage1_out |-> stage0_irq);

   p_disarm_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_wr && cf_addr == 12'h000 && !cf_wdata[0]) |=> (!stage0_irq && !stage1_out));

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stage0_irq && !rf_wr && !cf_wr) |=> stage0_irq);
endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rf_wr     (rf_wr),
   .rf_addr   (rf_addr),
   .cf_wr     (cf_wr),
   .cf_addr   (cf_addr),
   .cf_wdata  (cf_wdata),
   .sys_count (sys_count),
   .stage0_irq(stage0_irq),
   .stage1_out(stage1_out),
   .cmp_val   (cmp_val),
   .ofs_val   (ofs_val)
);

// File: tb/sim_wdog_twostage.sv
`timescale 1ns/1ps
module sim_wdog_twostage;
   localparam logic [31:0] IDV = 32'h0A1D_0057;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rf_wr = 0, rf_rd = 0, cf_wr = 0, cf_rd = 0;
   logic [11:0] rf_addr = 0, cf_addr = 0;
   logic [31:0] rf_wdata = 0, cf_wdata = 0;
   logic [31:0] rf_rdata, cf_rdata;
   logic [63:0] sys_count = 0;
   logic        stage0_irq, stage1_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   wdog_twostage u0 (
      .clk(clk), .rst_n(rst_n),
      .rf_wr(rf_wr), .rf_rd(rf_rd), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
      .cf_wr(cf_wr), .cf_rd(cf_rd), .cf_addr(cf_addr), .cf_wdata(cf_wdata), .cf_rdata(cf_rdata),
      .sys_count(sys_count), .stage0_irq(stage0_irq), .stage1_out(stage1_out)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr_c(input logic [11:0] a, input logic [31:0] d);
      cf_wr = 1; cf_addr = a; cf_wdata = d;
      @(negedge clk);
      cf_wr = 0;
   endtask

   task automatic wr_r(input logic [11:0] a, input logic [31:0] d);
      rf_wr = 1; rf_addr = a; rf_wdata = d;
      @(negedge clk);
      rf_wr = 0;
   endtask

   task automatic rd_c(input logic [11:0] a, output logic [31:0] v);
      cf_rd = 1; cf_addr = a;
      @(negedge clk);
      cf_rd = 0;
      v = cf_rdata;
   endtask

   task automatic rd_r(input logic [11:0] a, output logic [31:0] v);
      rf_rd = 1; rf_addr = a;
      @(negedge clk);
      rf_rd = 0;
      v = rf_rdata;
   endtask

   task automatic rd_cmp(output logic [63:0] v);
      logic [31:0] lo, hi;
      rd_c(12'h010, lo);
      rd_c(12'h014, hi);
      v = {hi, lo};
   endtask

   function automatic logic [31:0] ofs_pick(input int i);
      case (i)
         0: return 32'd0;
         1: return 32'd1;
         2: return 32'd2;
         3: return 32'd3;
         4: return 32'd7;
         default: return 32'd40;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [63:0] c64, base, y;
      logic [31:0] ofs;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 stage0", stage0_irq, 0);
      chk("R12 stage1", stage1_out, 0);
      rd_c(12'h000, v); chk("R12 ctrl", v, 0);
      rd_c(12'h008, v); chk("R12 offset", v, 0);
      rd_cmp(c64);      chk("R12 compare", c64, 0);

      // R9 identification and unmapped reads
      rd_c(12'hFCC, v); chk("R9 ctrl ident", v, IDV);
      rd_r(12'hFCC, v); chk("R9 kick ident", v, IDV);
      rd_c(12'h004, v); chk("R9 ctrl unmapped", v, 0);
      rd_r(12'h100, v); chk("R9 kick unmapped", v, 0);
      rd_r(12'h000, v); chk("R9 kick word reads 0", v, 0);

      // R10 read data held after strobe drops
      rd_c(12'hFCC, v);
      cf_addr = 12'h004;
      @(negedge clk);
      chk("R10 held data", cf_rdata, IDV);

      // R5/R6 sweep of offsets across a 32-bit carry
      for (int i = 0; i < 6; i++) begin
         ofs  = ofs_pick(i);
         base = 64'h0000_0001_FFFF_FFF0 - 64'd20 + 64'(i) * 64'd1000;
         sys_count = base;
         wr_c(12'h000, 32'h0);
         wr_c(12'h008, ofs);
         rd_c(12'h008, v); chk("R3 offset readback", v, ofs);
         rd_cmp(c64);      chk("R3 R4 compare after offset", c64, base + 64'(ofs));
         wr_c(12'h000, 32'h1);
         for (int k = 0; k <= 2 * int'(ofs) + 2; k++) begin
            logic [63:0] c;
            c = base + 64'(k);
            sys_count = c;
            @(negedge clk);
            chk("R5 stage0 sweep", stage0_irq, (c >= base + 64'(ofs)) ? 1 : 0);
            chk("R6 stage1 sweep", stage1_out,
                (c >= base + 64'(2 * ofs) + ((ofs == 0) ? 64'd1 : 64'd0)) ? 1 : 0);
         end
         rd_cmp(c64); chk("R5 compare reload", c64, base + 64'(2 * ofs));
         rd_c(12'h000, v); chk("R2 ctrl both flags", v, 32'h7);
      end

      // R8 sticky through count progress and unrelated writes; R4 compare writes ignored
      sys_count = sys_count + 64'd5000;
      repeat (4) @(negedge clk);
      wr_c(12'h010, 32'hFFFF_FFFF);
      wr_c(12'h014, 32'hFFFF_FFFF);
      wr_c(12'hFCC, 32'h1234_5678);
      chk("R8 stage0 sticky", stage0_irq, 1);
      chk("R8 stage1 sticky", stage1_out, 1);
      rd_cmp(c64); chk("R4 compare write ignored", c64, base + 64'd80);

      // R1 service write with arbitrary data
      y = 64'h0000_0003_0000_0100;
      sys_count = y;
      wr_r(12'h000, 32'hDEAD_BEEF);
      chk("R1 stage0 cleared", stage0_irq, 0);
      chk("R1 stage1 cleared", stage1_out, 0);
      rd_cmp(c64); chk("R1 compare restart", c64, y + 64'd40);
      sys_count = y + 64'd40;
      @(negedge clk);
      chk("R5 stage0 after restart", stage0_irq, 1);
      wr_r(12'h004, 32'h0);
      chk("R1 other kick address ignored", stage0_irq, 1);

      // R2 status bits ignore writes
      wr_c(12'h000, 32'h1);
      rd_c(12'h000, v); chk("R2 ctrl write keeps flag", v, 32'h3);

      // R7 disable clears and stays quiet
      wr_c(12'h000, 32'h6);
      rd_c(12'h000, v); chk("R7 ctrl after disable", v, 32'h0);
      sys_count = 64'hFFFF_0000_0000_0000;
      repeat (5) @(negedge clk);
      chk("R7 stage0 quiet", stage0_irq, 0);
      chk("R7 stage1 quiet", stage1_out, 0);

      // R11 service write on the expiry edge
      y = 64'h0000_0004_0000_0000;
      sys_count = y;
      wr_c(12'h008, 32'd10);
      wr_c(12'h000, 32'h1);
      sys_count = y + 64'd10;
      rf_wr = 1; rf_addr = 12'h000; rf_wdata = 32'h0;
      @(negedge clk);
      rf_wr = 0;
      chk("R11 kick beats expiry", stage0_irq, 0);
      rd_cmp(c64); chk("R11 compare", c64, y + 64'd20);
      chk("R11 still clear", stage0_irq, 0);

      // R3 offset write clears flags
      sys_count = y + 64'd20;
      @(negedge clk);
      chk("R5 stage0 set again", stage0_irq, 1);
      wr_c(12'h008, 32'd9);
      chk("R3 offset write clears", stage0_irq, 0);
      rd_cmp(c64); chk("R3 compare new offset", c64, y + 64'd29);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule